// File: doc/BRIEF.md
# SMBus Packet Error Check Engine

This block runs alongside the byte shifter of an SMBus host controller and keeps a CRC-8 over every byte that crosses the bus in a transaction. That includes the address bytes, the bytes the host sends and the bytes it receives. A start or repeated-start pulse resets the running value. Each byte strobe then folds one byte into it.

In automatic mode the block supplies the check byte for host writes. When the shifter signals end of data with no byte on the strobe, the block presents the computed value for one cycle so that it can be shifted out as the final byte. Any byte loaded by software is never used. On host reads, the trailing received byte is marked with the same end-of-data signal. The block folds that byte into the running value. A nonzero residue sets two sticky flags: a general device-error flag and a dedicated CRC-error flag. Each flag is cleared by its own write-one-to-clear pulse.

Automatic mode and the per-command manual check enable must not both be set. If they are, the block reports a configuration conflict and neither appends nor flags anything.

Top module: `smb_pec_engine`

## Requirements
- R1: The running value is CRC-8 with polynomial 0x07 and initial value 0x00, with bits taken MSB first. `crcValue` shows the updated value in the cycle after a `byteValid` strobe, and holds when there is no strobe.
- R2: `txnStart` returns `crcValue` to 0x00 in the next cycle. When it coincides with `byteValid`, the byte is folded into 0x00, which covers the address byte after a repeated start.
- R3: A byte is folded whatever its direction (`byteIsRx` 0 or 1), and whether or not it is an address byte.
- R4: With `autoCheckEn`=1 and `manualCheckEn`=0, `endOfData`=1 with `byteValid`=0 produces `appendValid`=1 for the next cycle. In that cycle `appendByte` equals the `crcValue` seen when the request was made.
- R5: With automatic mode active, a strobe with `byteValid`=`byteIsRx`=`endOfData`=1 marks the received check byte. If folding it gives a nonzero residue, `devErr` and `crcErr` are both 1 in the next cycle. A zero residue sets neither flag.
- R6: `devErr` and `crcErr` stay set until their own clear pulse (`clearDevErr`, `clearCrcErr`). Each pulse clears only its own flag. A new set in the same cycle as a clear wins over the clear.
- R7: When `autoCheckEn`=`manualCheckEn`=1, `cfgConflict` is 1 in the next cycle. In that state, end-of-data neither asserts `appendValid` nor sets any error flag.
- R8: With `autoCheckEn`=0, the CRC is still computed, but no byte is appended and no error flag is set.
- R9: After reset, `crcValue`=0x00, `appendValid`=0, `devErr`=0, `crcErr`=0 and `cfgConflict`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txnStart | input | 1 | Start or repeated-start pulse; clears the running CRC |
| byteValid | input | 1 | One byte on `byteData` to fold this cycle |
| byteIsRx | input | 1 | 1 when the byte was received by the host |
| byteData | input | 8 | Byte crossing the bus |
| endOfData | input | 1 | Without `byteValid`: request append on a write; with a received byte: marks it as the check byte |
| autoCheckEn | input | 1 | Automatic check mode enable |
| manualCheckEn | input | 1 | Manual per-command check enable |
| clearDevErr | input | 1 | Write-one-to-clear pulse for `devErr` |
| clearCrcErr | input | 1 | Write-one-to-clear pulse for `crcErr` |
| crcValue | output | 8 | Running CRC |
| appendValid | output | 1 | One-cycle strobe: `appendByte` is to be transmitted |
| appendByte | output | 8 | Computed check byte to transmit |
| devErr | output | 1 | Sticky device-error flag |
| crcErr | output | 1 | Sticky CRC-error flag |
| cfgConflict | output | 1 | Automatic and manual check both enabled |

## Verification
The assertions assume that `endOfData` for a write append arrives at least one cycle after the last byte strobe, so the captured value already includes that byte. They also assume that the two check enables are driven as levels, never as glitches inside a cycle. The bench respects both assumptions. It drives all inputs on the falling edge, leaves an idle cycle before every append request, and changes the mode bits only between transactions. Clear pulses are sent either alone or in the same cycle as a deliberate mismatch, so that the set-over-clear priority is exercised on purpose.

// File: rtl/smb_pec_pkg.sv
package smb_pec_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic clear;    // start / repeated start
    logic fold;     // fold byteData into running value
    logic capture;  // latch running value for append
  } pecStrb_t;

  function automatic logic [BYTE_W-1:0] crcStep(
      input logic [BYTE_W-1:0] crcIn,
      input logic [BYTE_W-1:0] dataIn,
      input logic [BYTE_W-1:0] poly);
    logic [BYTE_W-1:0] c;
    c = crcIn ^ dataIn;
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[BYTE_W-1] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/smb_pec_datapath.sv
module smb_pec_datapath
  import smb_pec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CRC_POLY = 8'h07,
  parameter logic [BYTE_W-1:0] CRC_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  pecStrb_t          strb,
  input  logic [BYTE_W-1:0] byteData,
  output logic [BYTE_W-1:0] crcValue,
  output logic [BYTE_W-1:0] appendByte,
  output logic              residueBad
);
  logic [BYTE_W-1:0] crcQ, appendQ, baseVal, foldVal;

  assign baseVal    = strb.clear ? CRC_INIT : crcQ;
  assign foldVal    = crcStep(baseVal, byteData, CRC_POLY);
  assign residueBad = (foldVal != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcQ    <= CRC_INIT;
      appendQ <= '0;
    end else begin
      if (strb.fold)       crcQ <= foldVal;
      else if (strb.clear) crcQ <= CRC_INIT;
      if (strb.capture)    appendQ <= crcQ;
    end
  end

  assign crcValue   = crcQ;
  assign appendByte = appendQ;

  assert_clear_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clear && !strb.fold) |=> (crcQ == CRC_INIT));

  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && !strb.fold) |=> $stable(crcQ));
endmodule

// File: rtl/smb_pec_control.sv
module smb_pec_control
  import smb_pec_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     txnStart,
  input  logic     byteValid,
  input  logic     byteIsRx,
  input  logic     endOfData,
  input  logic     autoCheckEn,
  input  logic     manualCheckEn,
  input  logic     clearDevErr,
  input  logic     clearCrcErr,
  input  logic     residueBad,
  output pecStrb_t strb,
  output logic     appendValid,
  output logic     devErr,
  output logic     crcErr,
  output logic     cfgConflict
);
  logic autoActive, appendReq, checkNow, mismatch;

  assign autoActive = autoCheckEn && !manualCheckEn;
  assign appendReq  = autoActive && endOfData && !byteValid;
  assign checkNow   = autoActive && endOfData && byteValid && byteIsRx;
  assign mismatch   = checkNow && residueBad;

  always_comb begin
    strb.clear   = txnStart;
    strb.fold    = byteValid;
    strb.capture = appendReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      appendValid <= 1'b0;
      devErr      <= 1'b0;
      crcErr      <= 1'b0;
      cfgConflict <= 1'b0;
    end else begin
      appendValid <= appendReq;
      cfgConflict <= autoCheckEn && manualCheckEn;
      if (mismatch)         devErr <= 1'b1;
      else if (clearDevErr) devErr <= 1'b0;
      if (mismatch)         crcErr <= 1'b1;
      else if (clearCrcErr) crcErr <= 1'b0;
    end
  end

  assert_no_append_conflict_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgConflict |-> !appendValid);

  assert_crc_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (crcErr && !clearCrcErr) |=> crcErr);

  assert_dev_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (devErr && !clearDevErr) |=> devErr);

  assert_flags_together_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcErr) |-> devErr);

  assert_no_flag_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !autoCheckEn |=> !$rose(crcErr));
endmodule

// File: rtl/smb_pec_engine.sv
module smb_pec_engine
  import smb_pec_pkg::*;
#(
  parameter logic [7:0] CRC_POLY = 8'h07,
  parameter logic [7:0] CRC_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txnStart,
  input  logic       byteValid,
  input  logic       byteIsRx,
  input  logic [7:0] byteData,
  input  logic       endOfData,
  input  logic       autoCheckEn,
  input  logic       manualCheckEn,
  input  logic       clearDevErr,
  input  logic       clearCrcErr,
  output logic [7:0] crcValue,
  output logic       appendValid,
  output logic [7:0] appendByte,
  output logic       devErr,
  output logic       crcErr,
  output logic       cfgConflict
);
  pecStrb_t strb;
  logic     residueBad;

  smb_pec_control u_ctrl (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .byteValid(byteValid),
    .byteIsRx(byteIsRx), .endOfData(endOfData), .autoCheckEn(autoCheckEn),
    .manualCheckEn(manualCheckEn), .clearDevErr(clearDevErr),
    .clearCrcErr(clearCrcErr), .residueBad(residueBad), .strb(strb),
    .appendValid(appendValid), .devErr(devErr), .crcErr(crcErr),
    .cfgConflict(cfgConflict)
  );

  smb_pec_datapath #(.CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData),
    .crcValue(crcValue), .appendByte(appendByte), .residueBad(residueBad)
  );

  assert_append_has_crc_R4: assert property (@(posedge clk) disable iff (!rstN)
    appendValid |-> (appendByte == $past(crcValue)));
endmodule

// File: tb/smb_pec_engine_tb.sv
module smb_pec_engine_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txnStart = 0, byteValid = 0, byteIsRx = 0, endOfData = 0;
  logic autoCheckEn = 0, manualCheckEn = 0, clearDevErr = 0, clearCrcErr = 0;
  logic [7:0] byteData = 0;
  logic [7:0] crcValue, appendByte;
  logic appendValid, devErr, crcErr, cfgConflict;
  int checks = 0;
  int errors = 0;
  logic [7:0] model = 0;

  always #4 clk = ~clk;

  smb_pec_engine u_dut (.*);

  function automatic logic [7:0] refStep(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    txnStart = 0; byteValid = 0; byteIsRx = 0; endOfData = 0;
    clearDevErr = 0; clearCrcErr = 0;
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] d, input logic rx, input logic st);
    txnStart = st; byteValid = 1; byteIsRx = rx; byteData = d; endOfData = 0;
    model = refStep(st ? 8'h00 : model, d);
    @(negedge clk);
    txnStart = 0; byteValid = 0;
  endtask

  task automatic testReset();
    check("R9 crc", crcValue, 8'h00);
    check("R9 append", appendValid, 0);
    check("R9 flags", {devErr, crcErr, cfgConflict}, 0);
  endtask

  task automatic testKnownVector();
    byte msg[9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    autoCheckEn = 1; manualCheckEn = 0;
    txnStart = 1; idle();
    check("R2 cleared", crcValue, 8'h00);
    foreach (msg[i]) begin
      sendByte(msg[i], 0, 0);
      check("R1 per-byte", crcValue, model);
    end
    check("R1 known vector", crcValue, 8'hF4);
    idle();
    check("R1 hold", crcValue, 8'hF4);
    endOfData = 1; @(negedge clk); endOfData = 0;
    check("R4 appendValid", appendValid, 1);
    check("R4 appendByte", appendByte, 8'hF4);
    idle();
    check("R4 single pulse", appendValid, 0);
  endtask

  task automatic testReadGood();
    logic [7:0] pec;
    sendByte(8'h20, 0, 1);
    sendByte(8'h05, 0, 0);
    sendByte(8'h21, 0, 1);
    check("R2 repeated start fold", crcValue, refStep(8'h00, 8'h21));
    sendByte(8'hA5, 1, 0);
    sendByte(8'h3C, 1, 0);
    check("R3 rx bytes folded", crcValue, model);
    pec = model;
    byteValid = 1; byteIsRx = 1; endOfData = 1; byteData = pec;
    @(negedge clk);
    idle();
    check("R5 good residue zero", crcValue, 8'h00);
    check("R5 no flags on match", {devErr, crcErr}, 2'b00);
  endtask

  task automatic testReadBad();
    sendByte(8'h21, 0, 1);
    sendByte(8'h77, 1, 0);
    byteValid = 1; byteIsRx = 1; endOfData = 1; byteData = model ^ 8'h01;
    @(negedge clk);
    idle();
    check("R5 devErr on mismatch", devErr, 1);
    check("R5 crcErr on mismatch", crcErr, 1);
    idle();
    check("R6 sticky", {devErr, crcErr}, 2'b11);
    clearCrcErr = 1; @(negedge clk); clearCrcErr = 0;
    check("R6 clear crc only", {devErr, crcErr}, 2'b10);
    clearDevErr = 1; @(negedge clk); clearDevErr = 0;
    check("R6 clear dev", {devErr, crcErr}, 2'b00);
    sendByte(8'h21, 0, 1);
    byteValid = 1; byteIsRx = 1; endOfData = 1; byteData = model ^ 8'h80;
    clearCrcErr = 1; clearDevErr = 1;
    @(negedge clk);
    idle();
    check("R6 set wins over clear", {devErr, crcErr}, 2'b11);
    clearCrcErr = 1; clearDevErr = 1; @(negedge clk); idle();
  endtask

  task automatic testConflict();
    manualCheckEn = 1; autoCheckEn = 1;
    sendByte(8'h40, 0, 1);
    check("R7 conflict flag", cfgConflict, 1);
    idle();
    endOfData = 1; @(negedge clk); endOfData = 0;
    check("R7 no append", appendValid, 0);
    sendByte(8'h41, 0, 1);
    byteValid = 1; byteIsRx = 1; endOfData = 1; byteData = model ^ 8'h55;
    @(negedge clk);
    idle();
    check("R7 no flags", {devErr, crcErr}, 2'b00);
    manualCheckEn = 0; idle();
    check("R7 conflict gone", cfgConflict, 0);
  endtask

  task automatic testAutoOff();
    autoCheckEn = 0; manualCheckEn = 0;
    sendByte(8'h10, 0, 1);
    sendByte(8'hFF, 0, 0);
    check("R8 crc still runs", crcValue, model);
    idle();
    endOfData = 1; @(negedge clk); endOfData = 0;
    check("R8 no append", appendValid, 0);
    byteValid = 1; byteIsRx = 1; endOfData = 1; byteData = model ^ 8'h0F;
    @(negedge clk);
    idle();
    check("R8 no flags", {devErr, crcErr}, 2'b00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1;
        @(negedge clk);
        testReset();
        testKnownVector();
        testReadGood();
        testReadBad();
        testConflict();
        testAutoOff();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule